// File: doc/BRIEF.md
# Packet Memory Arbiter with Read-Lane Alignment

This block owns the port of an external 32-bit packet SRAM made of four byte-wide devices. Two clients compete for it: the host port, which carries the pipelined accesses the CPU makes through the data register, and the DMA port, which moves frames to and from the MAC. The arbiter admits one client at a time and runs a memory cycle of exactly two clocks. With a 50 MHz clock that is 40 ns, so one host cycle and one DMA cycle fit inside an 80 ns window.

A write drives four active-low byte enables that follow the client's byte mask. The enables are low only in the second clock of the cycle. A read always fetches the whole word, whatever the requested size. The arbiter then shifts the selected byte or halfword down to the low lanes of the client's read bus and zeroes the lanes above it.

Each client holds its request until it receives a one-clock acknowledge. Read data is valid in the acknowledge cycle. A client that is being acknowledged is not granted again at the same clock edge. If both clients are waiting, the grants alternate between them.

Top module: `pram_arbiter`

## Requirements
- R1: After reset, both acknowledges are low, all four write enables are high (inactive) and the output enable is high.
- R2: A write changes only the byte lanes whose mask bit is set. Mask bit i covers data bits [8i+7:8i] of the word selected by address bits [AW-1:2].
- R3: During a write, the write enables are low for exactly one clock, which is the second clock of the cycle. The memory address and write data do not change while any enable is low.
- R4: A read with size code 2 returns the whole 32-bit word.
- R5: A read with size code 1 returns the halfword selected by address bit 1 on read bits [15:0]. Bits [31:16] are zero.
- R6: A read with size code 0 returns the byte selected by address bits [1:0] on read bits [7:0]. Bits [31:8] are zero.
- R7: From idle, a request present at a clock edge is acknowledged for exactly one clock, three clocks later. Read data is valid in that acknowledge cycle.
- R8: At most one access is in progress at a time, and the two acknowledges are never high in the same cycle.
- R9: When both clients hold their requests continuously, the acknowledges alternate between host and DMA. A host acknowledge then follows the previous one after exactly four clocks, which is 80 ns at 50 MHz.
- R10: A host request is acknowledged no more than six clocks after it is raised.
- R11: A read leaves all write enables high and never changes memory, even if its byte mask is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running arbiter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | Host access is a write |
| host_addr | input | AW | Host byte address |
| host_size | input | 2 | Host read size: 0 byte, 1 halfword, 2 word |
| host_be | input | 4 | Host write byte mask, one bit per lane |
| host_wdata | input | 32 | Host write data, lane-aligned |
| host_ack | output | 1 | One-clock host completion pulse |
| host_rdata | output | 32 | Host read data, right-aligned |
| dma_req | input | 1 | DMA access request, held until acknowledged |
| dma_we | input | 1 | DMA access is a write |
| dma_addr | input | AW | DMA byte address |
| dma_size | input | 2 | DMA read size: 0 byte, 1 halfword, 2 word |
| dma_be | input | 4 | DMA write byte mask |
| dma_wdata | input | 32 | DMA write data, lane-aligned |
| dma_ack | output | 1 | One-clock DMA completion pulse |
| dma_rdata | output | 32 | DMA read data, right-aligned |
| mem_addr | output | AW-2 | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_oe_n | output | 1 | SRAM output enable, active low, during reads |
| mem_we_n | output | 4 | SRAM byte write enables, active low |
| mem_rdata | input | 32 | SRAM read data |

## Verification
Two events can fall on the same clock edge: one client's access completes, and the other client's waiting access is granted. The bench provokes this by holding both requests high without a break. It then records the cycle of every acknowledge. The result is judged correct only if the acknowledges strictly alternate between the ports and each host acknowledge comes exactly four clocks after the previous one. The read data returned along the way must also match the bench's own memory image, which shows that back-to-back cycles did not mix up address or lane.

// File: rtl/pram_arbiter.sv
module pram_arbiter #(
  parameter int AW       = 15,
  parameter int HOST_MAX = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [1:0]    host_size,
  input  logic [3:0]    host_be,
  input  logic [31:0]   host_wdata,
  output logic          host_ack,
  output logic [31:0]   host_rdata,
  input  logic          dma_req,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [1:0]    dma_size,
  input  logic [3:0]    dma_be,
  input  logic [31:0]   dma_wdata,
  output logic          dma_ack,
  output logic [31:0]   dma_rdata,
  output logic [AW-3:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          mem_oe_n,
  output logic [3:0]    mem_we_n,
  input  logic [31:0]   mem_rdata
);

  logic          busy, phase, own;
  logic          c_we;
  logic [AW-1:0] c_addr;
  logic [1:0]    c_size;
  logic [3:0]    c_be;
  logic [31:0]   c_wd;

  wire free    = !busy || phase;
  wire h_ok    = host_req && !(busy && !own);
  wire d_ok    = dma_req  && !(busy && own);
  wire pick_d  = d_ok && (!h_ok || !own);
  wire start   = free && (h_ok || d_ok);
  wire done    = busy && phase;

  function automatic logic [31:0] steer(input logic [31:0] w, input logic [1:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    steer = {24'h0, w[8*a +: 8]};
      2'd1:    steer = {16'h0, w[16*a[1] +: 16]};
      default: steer = w;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; own <= 1'b1;
      c_we <= 1'b0; c_addr <= '0; c_size <= '0; c_be <= '0; c_wd <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      own    <= pick_d;
      c_we   <= pick_d ? dma_we    : host_we;
      c_addr <= pick_d ? dma_addr  : host_addr;
      c_size <= pick_d ? dma_size  : host_size;
      c_be   <= pick_d ? dma_be    : host_be;
      c_wd   <= pick_d ? dma_wdata : host_wdata;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      phase <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ack <= 1'b0; dma_ack <= 1'b0;
      host_rdata <= '0; dma_rdata <= '0;
    end else begin
      host_ack <= done && !own;
      dma_ack  <= done && own;
      if (done && !c_we && !own) host_rdata <= steer(mem_rdata, c_addr[1:0], c_size);
      if (done && !c_we &&  own) dma_rdata  <= steer(mem_rdata, c_addr[1:0], c_size);
    end
  end

  assign mem_addr  = c_addr[AW-1:2];
  assign mem_wdata = c_wd;
  assign mem_oe_n  = !(busy && !c_we);
  assign mem_we_n  = ~({4{done && c_we}} & c_be);

  logic [3:0] host_wait;
  always_ff @(posedge clk) begin
    if (!rst_n || !host_req || host_ack) host_wait <= '0;
    else if (host_wait != 4'hF)          host_wait <= host_wait + 4'd1;
  end

  AST_ONE_ACK:     assert property (@(posedge clk) disable iff (!rst_n) !(host_ack && dma_ack)); // R8
  AST_ACK_PULSE_H: assert property (@(posedge clk) disable iff (!rst_n) host_ack |=> !host_ack); // R7
  AST_ACK_PULSE_D: assert property (@(posedge clk) disable iff (!rst_n) dma_ack |=> !dma_ack); // R7
  AST_WE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n) (mem_we_n != 4'hF) |=> (host_ack || dma_ack)); // R3
  AST_WE_ONE_CLK:  assert property (@(posedge clk) disable iff (!rst_n) (mem_we_n != 4'hF) |=> (mem_we_n == 4'hF)); // R3
  AST_WE_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) (mem_we_n != 4'hF) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R3
  AST_READ_NO_WE:  assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> (mem_we_n == 4'hF)); // R11
  AST_HOST_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) host_wait <= 4'(HOST_MAX)); // R10

endmodule

// File: tb/pram_arbiter_test.sv
module pram_arbiter_test;
  localparam int AW = 6;
  localparam int NW = 1 << (AW - 2);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          host_req = 0, host_we = 0, dma_req = 0, dma_we = 0;
  logic [AW-1:0] host_addr = 0, dma_addr = 0;
  logic [1:0]    host_size = 0, dma_size = 0;
  logic [3:0]    host_be = 0, dma_be = 0;
  logic [31:0]   host_wdata = 0, dma_wdata = 0;
  logic          host_ack, dma_ack, mem_oe_n;
  logic [31:0]   host_rdata, dma_rdata, mem_wdata, mem_rdata;
  logic [AW-3:0] mem_addr;
  logic [3:0]    mem_we_n;

  pram_arbiter #(.AW(AW)) uut (.*);

  logic [31:0] mem [NW];
  logic [31:0] img [NW];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk)
    for (int i = 0; i < 4; i++)
      if (!mem_we_n[i]) mem[mem_addr][8*i +: 8] <= mem_wdata[8*i +: 8];

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int w);
    return 32'h9E37_79B9 * (w + 1) ^ 32'h5A00_00A5;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] w, input int a, input int sz);
    if (sz == 0) return (w >> (8 * (a % 4))) & 32'hFF;
    if (sz == 1) return (w >> (16 * ((a / 2) % 2))) & 32'hFFFF;
    return w;
  endfunction

  logic [31:0] rd;
  int lat;

  task automatic acc(input bit dma, input bit we, input int a, input int sz, input logic [3:0] be, input logic [31:0] wd);
    if (dma) begin dma_req = 1; dma_we = we; dma_addr = AW'(a); dma_size = 2'(sz); dma_be = be; dma_wdata = wd; end
    else     begin host_req = 1; host_we = we; host_addr = AW'(a); host_size = 2'(sz); host_be = be; host_wdata = wd; end
    lat = 0;
    do begin @(negedge clk); lat++; end while (!(dma ? dma_ack : host_ack) && lat < 50);
    rd = dma ? dma_rdata : host_rdata;
    if (dma) dma_req = 0; else host_req = 0;
    @(negedge clk);
    chk(dma ? "R7 one-cycle ack" : "R7 one-cycle ack", {31'h0, (dma ? dma_ack : host_ack)}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin mem[w] = 32'h0; img[w] = 32'h0; end
    repeat (3) @(negedge clk);
    chk("R1 acks low", {30'h0, host_ack, dma_ack}, 32'h0);
    chk("R1 we_n high", {28'h0, mem_we_n}, 32'hF);
    chk("R1 oe_n high", {31'h0, mem_oe_n}, 32'h1);
    rst_n = 1;
    @(negedge clk);

    for (int w = 0; w < NW; w++) begin
      acc(w % 2, 1, 4 * w, 2, 4'hF, pat(w));
      img[w] = pat(w);
      chk("R7 latency", 32'(lat), 32'd3);
    end

    for (int w = 0; w < NW; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int b = 0; b < 4; b++) begin
          acc((w + b) % 2, 0, 4 * w + b, sz, 4'h0, 32'h0);
          chk(sz == 0 ? "R6 byte read" : sz == 1 ? "R5 half read" : "R4 word read",
              rd, exp_read(img[w], 4 * w + b, sz));
        end

    for (int m = 0; m < 16; m++) begin
      automatic int w = m % NW;
      automatic logic [31:0] d = ~pat(m + 7);
      acc(m % 2, 1, 4 * w, 2, 4'(m), d);
      for (int i = 0; i < 4; i++) if (m[i]) img[w][8*i +: 8] = d[8*i +: 8];
      acc(1 - m % 2, 0, 4 * w, 2, 4'hF, 32'h0);
      chk("R2 masked write", rd, img[w]);
    end

    acc(0, 0, 8, 2, 4'hF, 32'hDEAD_BEEF);
    for (int w = 0; w < NW; w++) chk("R11 read no write", mem[w], img[w]);

    begin : saturate
      int lasth, prev;
      lasth = -1; prev = -1;
      host_we = 0; dma_we = 0; host_size = 2; dma_size = 2;
      host_addr = 4; dma_addr = 12;
      host_req = 1; dma_req = 1;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        chk("R8 single ack", {31'h0, host_ack && dma_ack}, 32'h0);
        if (host_ack) begin
          chk("R9 host data", host_rdata, img[1]);
          if (prev != -1) chk("R9 alternate", 32'(prev), 32'd1);
          if (lasth != -1) chk("R9 host spacing", 32'(c - lasth), 32'd4);
          lasth = c; prev = 0;
        end
        if (dma_ack) begin
          chk("R9 dma data", dma_rdata, img[3]);
          if (prev != -1) chk("R9 alternate", 32'(prev), 32'd0);
          prev = 1;
        end
      end
      host_req = 0; dma_req = 0;
      repeat (4) @(negedge clk);
    end

    dma_req = 1; dma_we = 0; dma_addr = 0;
    @(negedge clk);
    acc(0, 0, 0, 2, 4'h0, 32'h0);
    chk("R10 host bound", {31'h0, lat <= 6}, 32'h1);
    dma_req = 0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule